// File: doc/BRIEF.md
# SDRAM Power-Up and Mode-Register Sequencer

This block brings an SDRAM device from power-on to an operational state after every reset. It waits a parameterised number of cycles for the supply and clock to settle while driving NOP with clock enable high. It then closes every bank, issues two refresh cycles and writes the mode register. The mode word packs burst length, sequential/interleaved ordering, CAS latency, operating mode and the write-burst policy. When the final delay has passed, it raises a ready flag that hands the command bus to an access controller.

The controller is a single state machine. Its states are ST_POWER (settle wait), ST_PRE (precharge-all command), ST_WAIT_RP (precharge wait), ST_REF1 and ST_REF2 (refresh commands), ST_WAIT_RFC1 and ST_WAIT_RFC2 (refresh waits), ST_LMR (mode-register load), ST_WAIT_MRD (mode-register wait) and ST_READY. The transitions are:
- ST_POWER to ST_PRE when the settle timer expires.
- ST_PRE to ST_WAIT_RP, ST_REF1 to ST_WAIT_RFC1, ST_REF2 to ST_WAIT_RFC2 and ST_LMR to ST_WAIT_MRD, each unconditionally after one cycle, loading the timer.
- ST_WAIT_RP to ST_REF1, ST_WAIT_RFC1 to ST_REF2, ST_WAIT_RFC2 to ST_LMR and ST_WAIT_MRD to ST_READY, each on timer expiry.
- ST_READY holds until reset.

A down-counter shared by all waits provides the timing. A combinational packer builds the mode word. The delays TRP_CYC, TRFC_CYC and TMRD_CYC must each be at least 2.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is low, and in the cycle after release before the first rising edge, the outputs are: clock enable low, command inhibit ({cs_n,ras_n,cas_n,we_n}=1111), address and bank zero, and ready low. The reset is asynchronous.
- R2: Counting rising edges from reset release as k, every cycle with 1 <= k < PWR_CYC drives NOP (0111) with clock enable high.
- R3: At k = PWR_CYC the block drives precharge-all for one cycle. This is command 0010 with address bit 10 high, all other address bits zero and bank zero.
- R4: The first refresh command (0001, address and bank zero) appears at k = PWR_CYC + TRP_CYC. Every cycle between it and the precharge-all is NOP.
- R5: The second refresh appears TRFC_CYC cycles after the first, with NOP in between.
- R6: The mode-register load (0000, bank zero) appears TRFC_CYC cycles after the second refresh, with NOP in between.
- R7: During the mode-register load, the address carries the following fields: burst length in bits 2:0, interleave select in bit 3, CAS latency in bits 6:4, operating mode in bits 8:7, single-location writes in bit 9, and zero in bits 12:10.
- R8: Ready rises TMRD_CYC cycles after the mode-register load, with NOP in between. Afterwards it stays high with NOP and clock enable high until the next reset.
- R9: A reset asserted in the middle of the sequence returns the outputs at once to the R1 state. After release, the whole sequence restarts from the settle wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_burst_len | input | 3 | Burst length code for the mode word |
| cfg_interleave | input | 1 | 1 selects interleaved burst ordering |
| cfg_cas_lat | input | 3 | CAS latency code |
| cfg_op_mode | input | 2 | Operating mode code |
| cfg_wr_single | input | 1 | 1 selects single-location writes |
| cke | output | 1 | Clock enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W (13) | Address bus |
| ba | output | BANK_W (2) | Bank address |
| init_done | output | 1 | Sequence complete, bus handed over |

## Verification
The assertions rely on two conditions. The configuration inputs must stay constant from reset release until ready. Each wait parameter must be at least 2, so that two commands are never adjacent. The stimulus changes configuration only while reset is held low. It keeps the default delay parameters and uses three configuration words, one of them with every field at its maximum, to show that bits 12:10 stay zero. One of the three runs is cut short by a reset during the refresh wait.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [3:0] {
        ST_POWER,
        ST_PRE,
        ST_WAIT_RP,
        ST_REF1,
        ST_WAIT_RFC1,
        ST_REF2,
        ST_WAIT_RFC2,
        ST_LMR,
        ST_WAIT_MRD,
        ST_READY
    } init_state_e;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_INHIBIT = 4'b1111,
        CMD_NOP     = 4'b0111,
        CMD_PRE     = 4'b0010,
        CMD_REF     = 4'b0001,
        CMD_LMR     = 4'b0000
    } sdram_cmd_e;

    localparam int unsigned AP_BIT = 10;

endpackage

// File: rtl/init_wait_timer.sv
module init_wait_timer #(
    parameter int unsigned W     = 8,
    parameter int unsigned START = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= W'(START);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/init_mode_pack.sv
module init_mode_pack #(
    parameter int unsigned ADDR_W = 13
) (
    input  logic [2:0]        burst_len,
    input  logic              interleave,
    input  logic [2:0]        cas_lat,
    input  logic [1:0]        op_mode,
    input  logic              wr_single,
    output logic [ADDR_W-1:0] word
);

    localparam int unsigned BL_LSB = 0;
    localparam int unsigned BT_BIT = 3;
    localparam int unsigned CL_LSB = 4;
    localparam int unsigned OP_LSB = 7;
    localparam int unsigned WB_BIT = 9;

    always_comb begin
        word                    = '0;
        word[BL_LSB +: 3]       = burst_len;
        word[BT_BIT]            = interleave;
        word[CL_LSB +: 3]       = cas_lat;
        word[OP_LSB +: 2]       = op_mode;
        word[WB_BIT]            = wr_single;
    end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int unsigned ADDR_W   = 13,
    parameter int unsigned BANK_W   = 2,
    parameter int unsigned PWR_CYC  = 200,
    parameter int unsigned TRP_CYC  = 3,
    parameter int unsigned TRFC_CYC = 8,
    parameter int unsigned TMRD_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_burst_len,
    input  logic              cfg_interleave,
    input  logic [2:0]        cfg_cas_lat,
    input  logic [1:0]        cfg_op_mode,
    input  logic              cfg_wr_single,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] ba,
    output logic              init_done
);

    localparam int unsigned MAX_A = (PWR_CYC > TRFC_CYC) ? PWR_CYC : TRFC_CYC;
    localparam int unsigned MAX_B = (TRP_CYC > TMRD_CYC) ? TRP_CYC : TMRD_CYC;
    localparam int unsigned MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned TW    = $clog2(MAX_C + 1);

    init_state_e       st_q, st_d;
    logic              cke_q;
    logic              tmr_load;
    logic [TW-1:0]     tmr_val;
    logic              tmr_zero;
    logic [ADDR_W-1:0] mode_word;
    sdram_cmd_e        cmd;
    logic [ADDR_W-1:0] addr_d;

    init_wait_timer #(
        .W     (TW),
        .START (PWR_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    init_mode_pack #(
        .ADDR_W (ADDR_W)
    ) u_pack (
        .burst_len  (cfg_burst_len),
        .interleave (cfg_interleave),
        .cas_lat    (cfg_cas_lat),
        .op_mode    (cfg_op_mode),
        .wr_single  (cfg_wr_single),
        .word       (mode_word)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_POWER;
            cke_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cke_q <= 1'b1;
        end
    end

    // Next state and timer loads
    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (st_q)
            ST_POWER:     if (tmr_zero) st_d = ST_PRE;
            ST_PRE: begin
                st_d     = ST_WAIT_RP;
                tmr_load = 1'b1;
                tmr_val  = TW'(TRP_CYC - 2);
            end
            ST_WAIT_RP:   if (tmr_zero) st_d = ST_REF1;
            ST_REF1: begin
                st_d     = ST_WAIT_RFC1;
                tmr_load = 1'b1;
                tmr_val  = TW'(TRFC_CYC - 2);
            end
            ST_WAIT_RFC1: if (tmr_zero) st_d = ST_REF2;
            ST_REF2: begin
                st_d     = ST_WAIT_RFC2;
                tmr_load = 1'b1;
                tmr_val  = TW'(TRFC_CYC - 2);
            end
            ST_WAIT_RFC2: if (tmr_zero) st_d = ST_LMR;
            ST_LMR: begin
                st_d     = ST_WAIT_MRD;
                tmr_load = 1'b1;
                tmr_val  = TW'(TMRD_CYC - 2);
            end
            ST_WAIT_MRD:  if (tmr_zero) st_d = ST_READY;
            ST_READY:     st_d = ST_READY;
            default:      st_d = ST_POWER;
        endcase
    end

    // Outputs
    always_comb begin
        cmd    = CMD_NOP;
        addr_d = '0;
        unique case (st_q)
            ST_PRE: begin
                cmd            = CMD_PRE;
                addr_d[AP_BIT] = 1'b1;
            end
            ST_REF1, ST_REF2: cmd = CMD_REF;
            ST_LMR: begin
                cmd    = CMD_LMR;
                addr_d = mode_word;
            end
            default: cmd = CMD_NOP;
        endcase
        if (!cke_q) begin
            cmd    = CMD_INHIBIT;
            addr_d = '0;
        end
    end

    assign {cs_n, ras_n, cas_n, we_n} = cmd;
    assign cke       = cke_q;
    assign addr      = addr_d;
    assign ba        = '0;
    assign init_done = (st_q == ST_READY);

    // Checks on the pins
    logic [3:0] pin_cmd;
    logic       pin_active;
    assign pin_cmd    = {cs_n, ras_n, cas_n, we_n};
    assign pin_active = !cs_n && (pin_cmd != CMD_NOP);

    p_cmd_needs_cke_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> cke);

    p_pre_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd == CMD_PRE) |-> (addr == (ADDR_W'(1) << AP_BIT)) && (ba == '0));

    p_cmd_spaced_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pin_active |=> (pin_cmd == CMD_NOP));

    p_lmr_high_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd == CMD_LMR) |-> (addr[ADDR_W-1:AP_BIT] == '0) && (ba == '0));

    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (pin_cmd == CMD_NOP) && cke);

endmodule

// File: tb/sdram_init_seq_bench.sv
module sdram_init_seq_bench;

    localparam int PWR  = 200;
    localparam int TRP  = 3;
    localparam int TRFC = 8;
    localparam int TMRD = 2;
    localparam int AW   = 13;
    localparam int K_PRE = PWR;
    localparam int K_RF1 = K_PRE + TRP;
    localparam int K_RF2 = K_RF1 + TRFC;
    localparam int K_LMR = K_RF2 + TRFC;
    localparam int K_RDY = K_LMR + TMRD;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0;
    logic [2:0]    bl = '0;
    logic          seq = 1'b0;
    logic [2:0]    cl = '0;
    logic [1:0]    op = '0;
    logic          ws = 1'b0;
    logic          cke, cs_n, ras_n, cas_n, we_n, done;
    logic [AW-1:0] addr;
    logic [1:0]    ba;

    sdram_init_seq u_sdram_init_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_burst_len  (bl),
        .cfg_interleave (seq),
        .cfg_cas_lat    (cl),
        .cfg_op_mode    (op),
        .cfg_wr_single  (ws),
        .cke            (cke),
        .cs_n           (cs_n),
        .ras_n          (ras_n),
        .cas_n          (cas_n),
        .we_n           (we_n),
        .addr           (addr),
        .ba             (ba),
        .init_done      (done)
    );

    int    k;
    int    checks = 0;
    int    errors = 0;
    string rst_tag = "R1";

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) k <= 0;
        else        k <= k + 1;
    end

    function automatic logic [AW-1:0] mode_exp();
        logic [AW-1:0] m;
        m      = '0;
        m[2:0] = bl;
        m[3]   = seq;
        m[6:4] = cl;
        m[8:7] = op;
        m[9]   = ws;
        return m;
    endfunction

    task automatic cmp(input string tag, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s k=%0d actual=%h expected=%h", tag, k, act, exp);
        end
    endtask

    // Reference model: expected pins from the edge count since release
    task automatic check_cycle();
        logic [3:0]    e_cmd;
        logic [AW-1:0] e_addr;
        logic          e_cke, e_done;
        string         tag;
        e_cmd = 4'b0111; e_addr = '0; e_cke = 1'b1; e_done = 1'b0;
        if (!rst_n || k == 0) begin
            e_cmd = 4'b1111; e_cke = 1'b0;
            tag   = rst_n ? "R1" : rst_tag;
        end else if (k < K_PRE) begin
            tag = "R2";
        end else if (k == K_PRE) begin
            e_cmd = 4'b0010; e_addr[10] = 1'b1; tag = "R3";
        end else if (k <= K_RF1) begin
            tag = "R4";
            if (k == K_RF1) e_cmd = 4'b0001;
        end else if (k <= K_RF2) begin
            tag = "R5";
            if (k == K_RF2) e_cmd = 4'b0001;
        end else if (k <= K_LMR) begin
            tag = "R6";
            if (k == K_LMR) e_cmd = 4'b0000;
        end else begin
            tag    = "R8";
            e_done = (k >= K_RDY);
        end
        if (rst_n && k == K_LMR) begin
            cmp("R6", {16'd0, cs_n, ras_n, cas_n, we_n}, {16'd0, e_cmd});
            cmp("R7", {5'd0, addr, ba}, {5'd0, mode_exp(), 2'b00});
            cmp("R8", {18'd0, cke, done}, {18'd0, e_cke, e_done});
        end else begin
            cmp(tag, {cs_n, ras_n, cas_n, we_n, addr, ba, cke, done},
                     {e_cmd, e_addr, 2'b00, e_cke, e_done});
        end
    endtask

    task automatic run_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_cycle();
        end
    endtask

    task automatic do_reset(input string tag, input int n);
        @(negedge clk);
        rst_n   = 1'b0;
        rst_tag = tag;
        #1 check_cycle();
        run_cycles(n);
    endtask

    task automatic release_reset();
        @(negedge clk);
        rst_n = 1'b1;
        #1 check_cycle();
    endtask

    initial begin
        // Run 1: typical configuration, full sequence
        bl = 3'b011; seq = 1'b0; cl = 3'b010; op = 2'b00; ws = 1'b0;
        run_cycles(3);
        release_reset();
        run_cycles(K_RDY + 12);
        // Run 2: reset in the refresh wait (R9), then restart
        do_reset("R9", 3);
        bl = 3'b111; seq = 1'b1; cl = 3'b011; op = 2'b00; ws = 1'b1;
        release_reset();
        run_cycles(K_RF1 + 4);
        do_reset("R9", 2);
        release_reset();
        run_cycles(K_RDY + 12);
        // Run 3: all fields at maximum, bits 12:10 must stay zero (R7)
        do_reset("R1", 2);
        bl = 3'b111; seq = 1'b1; cl = 3'b111; op = 2'b11; ws = 1'b1;
        release_reset();
        run_cycles(K_RDY + 12);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired k=%0d actual=hung expected=finished", k);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule